// File: doc/BRIEF.md
# SMIC Host Transaction Engine

This block is a hardware master that runs one request/response exchange with a system-management controller through a three-register byte port (data, control/status, flags). A host fills a local request buffer and pulses a start strobe with the request length. The engine then pushes the request through the port one byte at a time, collects the reply into an internal 80-byte store and reports the outcome with a single-cycle pulse.

The exchange is polled and gated by flags. Every command the engine issues is echoed by the controller as a status code, and the engine checks that echo before it moves on. If a status does not match, a completion byte is non-zero, or the controller stays silent too long, the whole exchange starts again from the top, up to a fixed number of retries. When the engine is idle it watches the flags for pending controller traffic and raises an attention level.

Top module: `smic_xact_engine`

## Requirements
- R1: A start strobe with a length below 2 or above 80, or a strobe while a transaction is in progress, is refused: `rej_o` pulses one cycle later and no port write follows from it.
- R2: After a flags read (offset 2) that shows the busy bit (bit 0) set, the engine makes no access other than another flags read.
- R3: After each command, the engine writes the flags register (offset 2) with the value last read from it, ORed with 0x01.
- R4: The request goes out as control code 0x40 (status query, reply 0xC0 expected), then 0x41 with byte 0, 0x42 with each middle byte and 0x43 with the last byte. Control codes go to offset 1, request bytes to offset 0, and every control code lies in 0x40..0x46.
- R5: Codes 0x42 and 0x43 are only issued when the last flags read showed transmit-ready (bit 6).
- R6: After the 0x43 echo (0xC3), the byte at offset 0 must be zero; any other value makes the engine restart the transaction from the status query.
- R7: The reply is read after receive-ready (bit 7): 0x44, echo 0xC4, one byte, 0x45. A 0xC5 echo with receive-ready gives another byte and 0x45; a 0xC6 echo gives the last byte and 0x46. A final 0xC0 echo with a zero data byte ends the transaction with a `done_o` pulse, and `rsp_len_o` then equals the number of bytes received.
- R8: Each failed attempt counts one retry. When the count would exceed 3, `fail_o` pulses once and the engine returns to idle, so there are exactly four attempts.
- R9: If no step succeeds within `TIMEOUT_CYC` cycles, the attempt fails as in R6 and R8.
- R10: Reply bytes beyond 80 are dropped, `rsp_len_o` stays at 80 and `rsp_trunc_o` is set; a new transaction clears it.
- R11: While idle, `attn_o` is high exactly when the latest flags read has bit 4, 3 or 2 set. The receive-ready and transmit-ready flags do not raise it.
- R12: After reset no pulse is active. `done_o` and `fail_o` are single-cycle pulses and are never high together, and stored reply bytes can be read through `rsp_raddr_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe for a new transaction |
| req_len_i | input | 7 | Request length in bytes |
| req_addr_o | output | 7 | Index of the request byte being fetched |
| req_data_i | input | 8 | Request byte at `req_addr_o` |
| bus_addr_o | output | 2 | Port register offset: 0 data, 1 control/status, 2 flags |
| bus_rd_o | output | 1 | Port read strobe |
| bus_wr_o | output | 1 | Port write strobe |
| bus_wdata_o | output | 8 | Port write data |
| bus_rdata_i | input | 8 | Port read data, valid in the same cycle |
| rsp_raddr_i | input | 7 | Reply store read index |
| rsp_rdata_o | output | 8 | Reply byte at `rsp_raddr_i` |
| rsp_len_o | output | 7 | Reply length in bytes |
| rsp_trunc_o | output | 1 | Reply was longer than the store |
| done_o | output | 1 | Transaction completed |
| fail_o | output | 1 | Transaction abandoned after the retries |
| rej_o | output | 1 | Start strobe refused |
| attn_o | output | 1 | Controller has pending traffic (idle only) |

## Verification
`rej_o` and `attn_o` are registered, so each one is due on the edge after the strobe or the flags read that causes it. The bench samples them one falling edge after driving the stimulus. `done_o` and `fail_o` rise on the edge after the last data-register read or the last failed check. Because the port model adds random busy delays, the bench waits for these pulses in a bounded loop of falling edges. It then checks that each pulse lasts one cycle and compares the reply length, the reply bytes and the captured request against values it builds itself. Protocol rules (busy quiet, flags write-back, transmit-ready gating) are checked by the port model on every access.

// File: rtl/smic_pkg.sv
package smic_pkg;

  // port register offsets
  localparam logic [1:0] REG_DATA  = 2'd0;
  localparam logic [1:0] REG_CS    = 2'd1;
  localparam logic [1:0] REG_FLAGS = 2'd2;

  // flag bit positions
  localparam int FB_RX  = 7;
  localparam int FB_TX  = 6;
  localparam int FB_BSY = 0;
  localparam logic [7:0] ATTN_MASK = 8'h1C;

  // command codes and their echoes
  localparam logic [7:0] STAT_BIT    = 8'h80;
  localparam logic [7:0] CC_QUERY    = 8'h40;
  localparam logic [7:0] CC_WR_FIRST = 8'h41;
  localparam logic [7:0] CC_WR_MORE  = 8'h42;
  localparam logic [7:0] CC_WR_LAST  = 8'h43;
  localparam logic [7:0] CC_RD_FIRST = 8'h44;
  localparam logic [7:0] CC_RD_MORE  = 8'h45;
  localparam logic [7:0] CC_RD_LAST  = 8'h46;
  localparam logic [7:0] SC_READY    = STAT_BIT | CC_QUERY;
  localparam logic [7:0] SC_WR_FIRST = STAT_BIT | CC_WR_FIRST;
  localparam logic [7:0] SC_WR_MORE  = STAT_BIT | CC_WR_MORE;
  localparam logic [7:0] SC_WR_LAST  = STAT_BIT | CC_WR_LAST;
  localparam logic [7:0] SC_RD_FIRST = STAT_BIT | CC_RD_FIRST;
  localparam logic [7:0] SC_RD_MORE  = STAT_BIT | CC_RD_MORE;
  localparam logic [7:0] SC_RD_LAST  = STAT_BIT | CC_RD_LAST;

  // transaction step
  typedef enum logic [3:0] {
    X_IDLE, X_QUERY, X_ARM, X_WFIRST, X_WMORE, X_WLAST,
    X_TURN, X_RFIRST, X_RMORE, X_RLAST
  } xstate_e;

  // bus micro-phase within a step
  typedef enum logic [2:0] {
    B_FLAGS, B_STAT, B_DRD, B_CTRL, B_DWR, B_FWR
  } bphase_e;

  // meaning of a pending data-register read
  typedef enum logic [1:0] {
    RK_NONE, RK_KEEP, RK_CHECK
  } rkind_e;

endpackage

// File: rtl/smic_step_timer.sv
module smic_step_timer #(
  parameter int unsigned CYC = 5000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic reload_i,
  output logic expired_o
);
  localparam int TW = $clog2(CYC + 1);
  localparam logic [TW-1:0] LOAD = TW'(CYC);

  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (reload_i) cnt_d = LOAD;
    else if (run_i && (cnt_q != '0)) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= LOAD;
    else        cnt_q <= cnt_d;
  end

  assign expired_o = run_i && (cnt_q == '0);
endmodule

// File: rtl/smic_retry_ctr.sv
module smic_retry_ctr #(
  parameter int unsigned LIMIT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic inc_i,
  output logic spent_o
);
  localparam int RW = $clog2(LIMIT + 2);
  localparam logic [RW-1:0] TOP = RW'(LIMIT);

  logic [RW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)                    cnt_d = '0;
    else if (inc_i && !spent_o)   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // one more error now would exceed the limit
  assign spent_o = (cnt_q == TOP);
endmodule

// File: rtl/smic_rsp_store.sv
module smic_rsp_store #(
  parameter int unsigned DEPTH = 80,
  parameter int unsigned AW    = 7
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  localparam logic [AW-1:0] LIM = AW'(DEPTH);

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i && (waddr_i < LIM)) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = (raddr_i < LIM) ? mem_q[raddr_i] : 8'h00;
endmodule

// File: rtl/smic_xact_engine.sv
module smic_xact_engine
  import smic_pkg::*;
#(
  parameter int unsigned MAX_LEN     = 80,
  parameter int unsigned CLK_HZ      = 50000000,
  parameter int unsigned TIMEOUT_MS  = 100,
  parameter int unsigned TIMEOUT_CYC = CLK_HZ / 1000 * TIMEOUT_MS,
  parameter int unsigned RETRY_LIMIT = 3,
  localparam int LW = $clog2(MAX_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [LW-1:0] req_len_i,
  output logic [LW-1:0] req_addr_o,
  input  logic [7:0]    req_data_i,
  output logic [1:0]    bus_addr_o,
  output logic          bus_rd_o,
  output logic          bus_wr_o,
  output logic [7:0]    bus_wdata_o,
  input  logic [7:0]    bus_rdata_i,
  input  logic [LW-1:0] rsp_raddr_i,
  output logic [7:0]    rsp_rdata_o,
  output logic [LW-1:0] rsp_len_o,
  output logic          rsp_trunc_o,
  output logic          done_o,
  output logic          fail_o,
  output logic          rej_o,
  output logic          attn_o
);
  localparam logic [LW-1:0] MAX_L = LW'(MAX_LEN);
  localparam logic [LW-1:0] MIN_L = LW'(2);
  localparam logic [LW-1:0] ONE_L = LW'(1);

  xstate_e       xs_q, xs_d, nx_q, nx_d;
  bphase_e       ph_q, ph_d;
  rkind_e        rk_q, rk_d;
  logic [7:0]    flags_q, flags_d, cmd_q, cmd_d;
  logic          wdat_q, wdat_d;
  logic [LW-1:0] len_q, len_d, ptr_q, ptr_d, rcnt_q, rcnt_d;
  logic          trunc_q, trunc_d, attn_q, attn_d;
  logic          done_q, done_d, fail_q, fail_d, rej_q, rej_d;

  logic tmr_reload, tmr_exp, rty_clr, rty_inc, rty_spent;
  logic st_en, step_err, is_idle, len_ok, last_byte;
  logic [7:0] st;

  smic_step_timer #(.CYC(TIMEOUT_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .run_i(!is_idle),
    .reload_i(tmr_reload), .expired_o(tmr_exp)
  );

  smic_retry_ctr #(.LIMIT(RETRY_LIMIT)) u_rty (
    .clk(clk), .rst_n(rst_n), .clr_i(rty_clr),
    .inc_i(rty_inc), .spent_o(rty_spent)
  );

  smic_rsp_store #(.DEPTH(MAX_LEN), .AW(LW)) u_store (
    .clk(clk), .we_i(st_en), .waddr_i(rcnt_q), .wdata_i(bus_rdata_i),
    .raddr_i(rsp_raddr_i), .rdata_o(rsp_rdata_o)
  );

  assign is_idle   = (xs_q == X_IDLE);
  assign len_ok    = (req_len_i >= MIN_L) && (req_len_i <= MAX_L);
  assign last_byte = ((len_q - ptr_q) == ONE_L);
  assign st        = bus_rdata_i;

  always_comb begin
    xs_d = xs_q;  nx_d = nx_q;  ph_d = ph_q;  rk_d = rk_q;
    flags_d = flags_q;  cmd_d = cmd_q;  wdat_d = wdat_q;
    len_d = len_q;  ptr_d = ptr_q;  rcnt_d = rcnt_q;  trunc_d = trunc_q;
    attn_d = 1'b0;  done_d = 1'b0;  fail_d = 1'b0;  rej_d = 1'b0;
    bus_rd_o = 1'b0;  bus_wr_o = 1'b0;  bus_addr_o = REG_FLAGS;
    bus_wdata_o = 8'h00;
    tmr_reload = 1'b0;  rty_clr = 1'b0;  rty_inc = 1'b0;
    st_en = 1'b0;  step_err = 1'b0;

    if (start_i) begin
      if (is_idle && len_ok) begin
        xs_d = X_QUERY;  ph_d = B_FLAGS;  len_d = req_len_i;
        ptr_d = '0;  rcnt_d = '0;  trunc_d = 1'b0;
        rty_clr = 1'b1;  tmr_reload = 1'b1;
      end else begin
        rej_d = 1'b1;
      end
    end

    if (is_idle) begin
      // watch for pending controller traffic
      bus_rd_o = 1'b1;
      bus_addr_o = REG_FLAGS;
      attn_d = |(bus_rdata_i & ATTN_MASK);
    end else if (tmr_exp) begin
      step_err = 1'b1;
    end else begin
      unique case (ph_q)
        B_FLAGS: begin
          bus_rd_o = 1'b1;
          bus_addr_o = REG_FLAGS;
          flags_d = bus_rdata_i;
          if (!bus_rdata_i[FB_BSY]) ph_d = B_STAT;
        end
        B_STAT: begin
          bus_rd_o = 1'b1;
          bus_addr_o = REG_CS;
          ph_d = B_CTRL;  rk_d = RK_NONE;  wdat_d = 1'b0;
          unique case (xs_q)
            X_QUERY: begin
              cmd_d = CC_QUERY;  nx_d = X_ARM;
            end
            X_ARM: begin
              if (st != SC_READY) step_err = 1'b1;
              else begin cmd_d = CC_WR_FIRST; nx_d = X_WFIRST; wdat_d = 1'b1; end
            end
            X_WFIRST, X_WMORE: begin
              if (st != ((xs_q == X_WFIRST) ? SC_WR_FIRST : SC_WR_MORE)) step_err = 1'b1;
              else if (!flags_q[FB_TX]) ph_d = B_FLAGS;
              else begin
                cmd_d  = last_byte ? CC_WR_LAST : CC_WR_MORE;
                nx_d   = last_byte ? X_WLAST : X_WMORE;
                wdat_d = 1'b1;
              end
            end
            X_WLAST: begin
              if (st != SC_WR_LAST) step_err = 1'b1;
              else begin rk_d = RK_CHECK; nx_d = X_TURN; ph_d = B_DRD; end
            end
            X_TURN: begin
              if (!flags_q[FB_RX]) ph_d = B_FLAGS;
              else begin cmd_d = CC_RD_FIRST; nx_d = X_RFIRST; end
            end
            X_RFIRST: begin
              if (st != SC_RD_FIRST) step_err = 1'b1;
              else if (!flags_q[FB_RX]) ph_d = B_FLAGS;
              else begin cmd_d = CC_RD_MORE; nx_d = X_RMORE; rk_d = RK_KEEP; ph_d = B_DRD; end
            end
            X_RMORE: begin
              if (st == SC_RD_LAST) begin
                cmd_d = CC_RD_LAST; nx_d = X_RLAST; rk_d = RK_KEEP; ph_d = B_DRD;
              end else if (st == SC_RD_MORE) begin
                if (!flags_q[FB_RX]) ph_d = B_FLAGS;
                else begin cmd_d = CC_RD_MORE; nx_d = X_RMORE; rk_d = RK_KEEP; ph_d = B_DRD; end
              end else begin
                step_err = 1'b1;
              end
            end
            X_RLAST: begin
              if (st != SC_READY) step_err = 1'b1;
              else begin rk_d = RK_CHECK; nx_d = X_IDLE; ph_d = B_DRD; end
            end
            default: step_err = 1'b1;
          endcase
        end
        B_DRD: begin
          bus_rd_o = 1'b1;
          bus_addr_o = REG_DATA;
          if (rk_q == RK_KEEP) begin
            if (rcnt_q < MAX_L) begin
              st_en = 1'b1;
              rcnt_d = rcnt_q + 1'b1;
            end else begin
              trunc_d = 1'b1;
            end
            ph_d = B_CTRL;
          end else if (bus_rdata_i != 8'h00) begin
            step_err = 1'b1;
          end else begin
            xs_d = nx_q;  ph_d = B_FLAGS;  tmr_reload = 1'b1;
            done_d = (nx_q == X_IDLE);
          end
        end
        B_CTRL: begin
          bus_wr_o = 1'b1;
          bus_addr_o = REG_CS;
          bus_wdata_o = cmd_q;
          ph_d = wdat_q ? B_DWR : B_FWR;
        end
        B_DWR: begin
          bus_wr_o = 1'b1;
          bus_addr_o = REG_DATA;
          bus_wdata_o = req_data_i;
          ptr_d = ptr_q + 1'b1;
          ph_d = B_FWR;
        end
        B_FWR: begin
          bus_wr_o = 1'b1;
          bus_addr_o = REG_FLAGS;
          bus_wdata_o = flags_q | 8'h01;
          xs_d = nx_q;  ph_d = B_FLAGS;  tmr_reload = 1'b1;
        end
        default: ph_d = B_FLAGS;
      endcase
    end

    if (step_err) begin
      rty_inc = 1'b1;
      ph_d = B_FLAGS;
      ptr_d = '0;  rcnt_d = '0;  trunc_d = 1'b0;
      tmr_reload = 1'b1;
      if (rty_spent) begin
        fail_d = 1'b1;
        xs_d = X_IDLE;
      end else begin
        xs_d = X_QUERY;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xs_q <= X_IDLE;  nx_q <= X_IDLE;  ph_q <= B_FLAGS;  rk_q <= RK_NONE;
      flags_q <= 8'h00;  cmd_q <= 8'h00;  wdat_q <= 1'b0;
      len_q <= '0;  ptr_q <= '0;  rcnt_q <= '0;  trunc_q <= 1'b0;
      attn_q <= 1'b0;  done_q <= 1'b0;  fail_q <= 1'b0;  rej_q <= 1'b0;
    end else begin
      xs_q <= xs_d;  nx_q <= nx_d;  ph_q <= ph_d;  rk_q <= rk_d;
      flags_q <= flags_d;  cmd_q <= cmd_d;  wdat_q <= wdat_d;
      len_q <= len_d;  ptr_q <= ptr_d;  rcnt_q <= rcnt_d;  trunc_q <= trunc_d;
      attn_q <= attn_d;  done_q <= done_d;  fail_q <= fail_d;  rej_q <= rej_d;
    end
  end

  assign req_addr_o  = ptr_q;
  assign rsp_len_o   = rcnt_q;
  assign rsp_trunc_o = trunc_q;
  assign done_o      = done_q;
  assign fail_o      = fail_q;
  assign rej_o       = rej_q;
  assign attn_o      = attn_q;
endmodule

// File: rtl/smic_xact_chk.sv
module smic_xact_chk #(
  parameter int unsigned MAX_LEN = 80,
  localparam int LW = $clog2(MAX_LEN + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic [LW-1:0] req_len_i,
  input logic [1:0]    bus_addr_o,
  input logic          bus_rd_o,
  input logic          bus_wr_o,
  input logic [7:0]    bus_wdata_o,
  input logic [7:0]    bus_rdata_i,
  input logic [LW-1:0] rsp_len_o,
  input logic          done_o,
  input logic          fail_o,
  input logic          rej_o
);
  localparam logic [LW-1:0] MAX_L = LW'(MAX_LEN);

  AST_REJECT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && ((req_len_i < LW'(2)) || (req_len_i > MAX_L))) |=> rej_o); // R1

  AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_o && (bus_addr_o == 2'd2) && bus_rdata_i[0]) |=> !bus_wr_o); // R2

  AST_FLAGS_BUSY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_o && (bus_addr_o == 2'd2)) |-> bus_wdata_o[0]); // R3

  AST_CTRL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_o && (bus_addr_o == 2'd1)) |-> ((bus_wdata_o >= 8'h40) && (bus_wdata_o <= 8'h46))); // R4

  AST_DONE_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(bus_rd_o && (bus_addr_o == 2'd0))); // R7

  AST_RSP_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_len_o <= MAX_L); // R10

  AST_END_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && fail_o)); // R12

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R12
endmodule

bind smic_xact_engine smic_xact_chk #(.MAX_LEN(MAX_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .req_len_i(req_len_i),
  .bus_addr_o(bus_addr_o), .bus_rd_o(bus_rd_o), .bus_wr_o(bus_wr_o),
  .bus_wdata_o(bus_wdata_o), .bus_rdata_i(bus_rdata_i),
  .rsp_len_o(rsp_len_o), .done_o(done_o), .fail_o(fail_o), .rej_o(rej_o)
);

// File: tb/smic_xact_engine_tb.sv
module smic_xact_engine_tb;
  localparam int MAXL = 80;
  localparam int LW   = 7;
  localparam int TOC  = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          start_i = 1'b0;
  logic [LW-1:0] req_len_i = '0;
  logic [LW-1:0] req_addr_o;
  logic [7:0]    req_data_i;
  logic [1:0]    bus_addr_o;
  logic          bus_rd_o, bus_wr_o;
  logic [7:0]    bus_wdata_o, bus_rdata_i;
  logic [LW-1:0] rsp_raddr_i = '0;
  logic [7:0]    rsp_rdata_o;
  logic [LW-1:0] rsp_len_o;
  logic          rsp_trunc_o, done_o, fail_o, rej_o, attn_o;

  smic_xact_engine #(.MAX_LEN(MAXL), .TIMEOUT_CYC(TOC)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .req_len_i(req_len_i),
    .req_addr_o(req_addr_o), .req_data_i(req_data_i),
    .bus_addr_o(bus_addr_o), .bus_rd_o(bus_rd_o), .bus_wr_o(bus_wr_o),
    .bus_wdata_o(bus_wdata_o), .bus_rdata_i(bus_rdata_i),
    .rsp_raddr_i(rsp_raddr_i), .rsp_rdata_o(rsp_rdata_o),
    .rsp_len_o(rsp_len_o), .rsp_trunc_o(rsp_trunc_o),
    .done_o(done_o), .fail_o(fail_o), .rej_o(rej_o), .attn_o(attn_o)
  );

  // ---------------- stimulus configuration (written by initial only)
  logic [7:0] req_mem [128];
  logic [7:0] resp [100];
  int  resp_n = 3;
  logic tx_en = 1'b1;
  logic [2:0] attn_bits = 3'b000;
  logic stuck = 1'b0;
  logic bad_stat = 1'b0;
  int  err_at = -1;
  int  dly_max = 3;

  assign req_data_i = req_mem[req_addr_o];

  // ---------------- port model (written by this process only)
  logic m_busy, m_rx;
  logic [7:0] m_status, m_data, m_cmd, last_fr;
  int m_cnt, m_idx;
  int n_wrstart, n_query, n_wrmore, cap_n;
  int viol_busy, viol_fl, viol_tx;
  logic [7:0] cap [100];
  logic [7:0] m_flags;

  assign m_flags = {m_rx, tx_en, 1'b0, attn_bits, 1'b0, m_busy};
  assign bus_rdata_i = (bus_addr_o == 2'd0) ? m_data :
                       (bus_addr_o == 2'd1) ? m_status :
                       (bus_addr_o == 2'd2) ? m_flags : 8'h00;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy <= 1'b0; m_rx <= 1'b0; m_status <= 8'hC0; m_data <= 8'h00;
      m_cmd <= 8'h00; last_fr <= 8'h00; m_cnt <= 0; m_idx <= 0;
      n_wrstart <= 0; n_query <= 0; n_wrmore <= 0; cap_n <= 0;
      viol_busy <= 0; viol_fl <= 0; viol_tx <= 0;
    end else begin
      if (bus_rd_o && bus_addr_o == 2'd2) last_fr <= m_flags;
      if (m_busy && (bus_wr_o || (bus_rd_o && bus_addr_o != 2'd2))) viol_busy <= viol_busy + 1;
      if (bus_wr_o && bus_addr_o == 2'd1) begin
        m_cmd <= bus_wdata_o;
        if (bus_wdata_o == 8'h40) n_query <= n_query + 1;
        if (bus_wdata_o == 8'h41) begin n_wrstart <= n_wrstart + 1; cap_n <= 0; end
        if (bus_wdata_o == 8'h42 || bus_wdata_o == 8'h43) begin
          n_wrmore <= n_wrmore + 1;
          if (!last_fr[6]) viol_tx <= viol_tx + 1;
        end
      end
      if (bus_wr_o && bus_addr_o == 2'd0) begin
        cap[cap_n] <= bus_wdata_o;
        cap_n <= cap_n + 1;
      end
      if (bus_wr_o && bus_addr_o == 2'd2) begin
        if (bus_wdata_o != (last_fr | 8'h01)) viol_fl <= viol_fl + 1;
        if (bus_wdata_o[0]) begin
          m_busy <= 1'b1;
          m_cnt <= int'($urandom_range(dly_max, 0));
        end
      end
      if (m_busy && !stuck) begin
        if (m_cnt == 0) begin
          m_busy <= 1'b0;
          case (m_cmd)
            8'h40: begin m_status <= bad_stat ? 8'hC7 : 8'hC0; m_rx <= 1'b0; end
            8'h41: m_status <= 8'hC1;
            8'h42: m_status <= 8'hC2;
            8'h43: begin
              m_status <= 8'hC3;
              m_data <= (n_wrstart == err_at) ? 8'h5A : 8'h00;
              m_rx <= 1'b1;
            end
            8'h44: begin m_status <= 8'hC4; m_data <= resp[0]; m_idx <= 0; end
            8'h45: begin
              m_status <= (m_idx + 1 >= resp_n - 1) ? 8'hC6 : 8'hC5;
              m_data <= resp[m_idx + 1];
              m_idx <= m_idx + 1;
            end
            8'h46: begin m_status <= 8'hC0; m_data <= 8'h00; m_rx <= 1'b0; end
            default: m_status <= 8'hCF;
          endcase
        end else begin
          m_cnt <= m_cnt - 1;
        end
      end
    end
  end

  // ---------------- bookkeeping
  int total = 0;
  int bad = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input logic ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic pulse_start(input int len);
    @(negedge clk);
    start_i = 1'b1;
    req_len_i = LW'(len);
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // waits for done or fail; returns which and the elapsed cycles
  task automatic wait_end(input int lim, output int got, output int el);
    got = 0;
    el = 0;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      el = i + 1;
      if (done_o) begin got = 1; break; end
      if (fail_o) begin got = 2; break; end
    end
  endtask

  function automatic int exp_len(input int n);
    return (n > MAXL) ? MAXL : n;
  endfunction

  task automatic fill(input int len, input int rn);
    for (int i = 0; i < len; i++) req_mem[i] = 8'($urandom);
    for (int i = 0; i < rn; i++) resp[i] = 8'($urandom);
    resp_n = rn;
  endtask

  task automatic run_ok(input int len, input int rn, input string tag);
    int got, el, ws0, mism;
    ws0 = n_wrstart;
    fill(len, rn);
    pulse_start(len);
    wait_end(20000, got, el);
    chk(got == 1, {tag, " R7 done pulse"}, got, 1);
    @(negedge clk);
    chk(done_o == 1'b0, {tag, " R12 done single cycle"}, int'(done_o), 0);
    chk(rsp_len_o == LW'(exp_len(rn)), {tag, " R7 reply length"}, int'(rsp_len_o), exp_len(rn));
    chk(rsp_trunc_o == (rn > MAXL), {tag, " R10 trunc flag"}, int'(rsp_trunc_o), int'(rn > MAXL));
    mism = 0;
    for (int i = 0; i < exp_len(rn); i++) begin
      rsp_raddr_i = LW'(i);
      #1;
      if (rsp_rdata_o != resp[i]) mism++;
    end
    chk(mism == 0, {tag, " R7 reply bytes"}, mism, 0);
    chk(cap_n == len, {tag, " R4 request byte count"}, cap_n, len);
    mism = 0;
    for (int i = 0; i < len; i++) if (cap[i] != req_mem[i]) mism++;
    chk(mism == 0, {tag, " R4 request bytes"}, mism, 0);
    if (err_at < 0)
      chk(n_wrstart - ws0 == 1, {tag, " R4 single attempt"}, n_wrstart - ws0, 1);
  endtask

  int got, el, q0, w0, x0;

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 128; i++) req_mem[i] = 8'h00;
    for (int i = 0; i < 100; i++) resp[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    chk(done_o == 1'b0 && fail_o == 1'b0 && rej_o == 1'b0, "R12 no pulse after reset", int'({done_o, fail_o, rej_o}), 0);
    chk(rsp_len_o == '0, "R12 reply length after reset", int'(rsp_len_o), 0);
    chk(attn_o == 1'b0, "R11 attention after reset", int'(attn_o), 0);

    // R1: length limits
    q0 = n_query;
    pulse_start(1);
    chk(rej_o == 1'b1, "R1 length 1 refused", int'(rej_o), 1);
    pulse_start(81);
    chk(rej_o == 1'b1, "R1 length 81 refused", int'(rej_o), 1);
    x0 = 0;
    for (int i = 0; i < 10; i++) begin @(negedge clk); if (bus_wr_o) x0++; end
    chk(x0 == 0 && n_query == q0, "R1 no port write after refusal", x0, 0);

    // directed boundary lengths
    run_ok(2, 3, "len2");
    run_ok(80, 4, "len80");
    run_ok(5, 2, "rsp2");

    // random transactions
    for (int k = 0; k < 10; k++) begin
      dly_max = int'($urandom_range(4, 0));
      run_ok(int'($urandom_range(80, 2)), int'($urandom_range(20, 3)), "rand");
    end

    // R1: start while busy
    fill(10, 5);
    pulse_start(10);
    repeat (3) @(negedge clk);
    pulse_start(10);
    chk(rej_o == 1'b1, "R1 start while busy refused", int'(rej_o), 1);
    wait_end(20000, got, el);
    chk(got == 1, "R1 running transaction unaffected", got, 1);

    // R5: transmit-ready gating
    tx_en = 1'b0;
    w0 = n_wrmore;
    fill(6, 4);
    pulse_start(6);
    repeat (100) @(negedge clk);
    chk(n_wrmore == w0, "R5 no write-next while not ready", n_wrmore - w0, 0);
    tx_en = 1'b1;
    wait_end(20000, got, el);
    chk(got == 1, "R5 completes once ready", got, 1);

    // R6: non-zero completion byte once
    err_at = n_wrstart + 1;
    w0 = n_wrstart;
    run_ok(7, 5, "R6");
    chk(n_wrstart - w0 == 2, "R6 one restart after error byte", n_wrstart - w0, 2);
    err_at = -1;

    // R8: bad status every time
    bad_stat = 1'b1;
    q0 = n_query;
    fill(4, 3);
    pulse_start(4);
    wait_end(20000, got, el);
    chk(got == 2, "R8 fail pulse", got, 2);
    chk(n_query - q0 == 4, "R8 four attempts", n_query - q0, 4);
    @(negedge clk);
    chk(fail_o == 1'b0, "R12 fail single cycle", int'(fail_o), 0);
    bad_stat = 1'b0;
    run_ok(4, 3, "R8 recovery");

    // R9: controller stays busy
    stuck = 1'b1;
    fill(4, 3);
    pulse_start(4);
    wait_end(20000, got, el);
    chk(got == 2, "R9 timeout fail", got, 2);
    chk(el >= 4 * TOC && el <= 4 * TOC + 60, "R9 timeout duration", el, 4 * TOC);
    stuck = 1'b0;
    repeat (20) @(negedge clk);

    // R10: overlong reply, then cleared
    run_ok(3, 85, "R10 long");
    run_ok(3, 6, "R10 cleared");

    // R11: attention bits
    for (int b = 0; b < 3; b++) begin
      attn_bits = 3'(1 << b);
      repeat (2) @(negedge clk);
      chk(attn_o == 1'b1, "R11 attention bit", int'(attn_o), 1);
    end
    attn_bits = 3'b000;
    repeat (2) @(negedge clk);
    chk(attn_o == 1'b0, "R11 attention clear with tx-ready set", int'(attn_o), 0);

    // protocol rule counters
    chk(viol_busy == 0, "R2 access while busy", viol_busy, 0);
    chk(viol_fl == 0, "R3 flags write-back value", viol_fl, 0);
    chk(viol_tx == 0, "R5 write-next without tx-ready", viol_tx, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cyc >= 150000);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule